// File: doc/BRIEF.md
# Single-Precision Reciprocal Estimate Unit

This unit returns a coarse approximation of 1/x for a 32-bit IEEE-754 single-precision operand. The approximation carries eight significant fraction bits. It is meant to seed an iterative reciprocal or divide sequence that lives outside the block. A shift-subtract network derives the estimate from a fixed 9-bit integer rule, so the unit needs neither a stored table nor a full-width divider.

All special operands are resolved inside the block: NaNs (quiet, signalling, or replaced by the default NaN), infinities, zeros, operands so small that their reciprocal overflows, operands so large that their reciprocal underflows, and subnormal operands. Subnormals are either normalised or squashed to zero, depending on the flush-to-zero control. Each accepted operand produces a result and a set of exception flags one clock later.

The operand is presented with `in_valid`. The rounding-mode and mode-control inputs travel with the operand. The result and flags are registered, and they keep their value until the next accepted operand.

Top module: `fp_recip_estimate`

## Requirements
- R1: A cycle with `in_valid` high loads `result` and `flags` at that clock edge, and `out_valid` is high for exactly the following cycle. When `in_valid` is low, `result` and `flags` hold their value. Reset clears `out_valid`, `result` and `flags` to zero. Flag bits are: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact, bit 5 input-denormal.
- R2: A NaN operand returns the same NaN with fraction bit 22 forced to one. The invalid flag is raised only when that bit was zero on input, which marks a signalling NaN.
- R3: With `dnan` high, any NaN operand returns 0x7FC00000. Invalid is still raised for a signalling NaN.
- R4: An infinite operand returns zero with the operand's sign and no flag. A zero operand returns infinity with the operand's sign and raises divide-by-zero.
- R5: A nonzero operand whose magnitude field (bits 30:0) is below 0x00200000 raises overflow and inexact. It returns signed infinity when the rounding mode tends to infinity for that sign, and otherwise ±0x7F7FFFFF. Rounding-mode encoding: 0 nearest (always infinity), 1 toward +inf (infinity if positive), 2 toward −inf (infinity if negative), 3 toward zero (never infinity).
- R6: With `ftz` high and a biased exponent of 253 or 254, the result is zero with the operand's sign and the underflow flag is raised. With `ftz` low, exponent 253 gives a subnormal result whose fraction is a leading one followed by the estimate shifted right by one. Exponent 254 gives a fraction of binary 01 followed by the estimate shifted right by two. Examples: 0x7E800000 → 0x007FC000 and 0x7F000000 → 0x003FE000.
- R7: With `ftz` high, a subnormal operand is treated as a zero of the same sign: the result is signed infinity and the flags are divide-by-zero plus input-denormal.
- R8: For a normal operand with biased exponent e, the index is i = 256 + fraction bits 22:15 and the estimate is (floor(2^19/(2i+1)) + 1) >> 1. The result exponent is 253 − e, the low eight estimate bits fill fraction bits 22:15, and the remaining fraction bits are zero. Examples: 0x3F800000 → 0x3F7F8000 and 0x3FC00000 → 0x3F2A8000.
- R9: With `ftz` low, a subnormal operand is first normalised. If fraction bit 22 is set, the fraction is shifted left by one and the exponent is taken as 0. Otherwise it is shifted left by two and the exponent is taken as −1. Examples: 0x00400000 → 0x7EFF8000 and 0x00200000 → 0x7F7F8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| operand | input | 32 | Single-precision input value |
| rmode | input | 2 | Rounding mode used for the overflow case |
| ftz | input | 1 | Flush subnormal inputs and underflowing results to zero |
| dnan | input | 1 | Return the default NaN for any NaN operand |
| out_valid | output | 1 | Result registered from the previous cycle's operand |
| result | output | 32 | Reciprocal estimate |
| flags | output | 6 | Exception flags of the last accepted operand |

## Verification
The bench builds the unit with its default widths: an 8-bit exponent, a 23-bit fraction and a 9-bit seed. With these widths the exact single-precision boundaries can be driven directly. These include the 0x00200000 tiny limit, exponents 252, 253 and 254 on both sides of the flush rule, and the two subnormal-normalisation shifts. The estimate corners at index 256 and 511 give the largest (0xFF) and smallest (0x00) estimate fields, and an index of 384 gives a mid-range value of 0x55. All of these results are computed by hand from the requirements.

// File: rtl/recip_pkg.sv
package recip_pkg;

  typedef enum logic [2:0] {
    CL_NORM  = 3'd0,
    CL_NAN   = 3'd1,
    CL_INF   = 3'd2,
    CL_ZERO  = 3'd3,
    CL_TINY  = 3'd4,
    CL_UFLOW = 3'd5
  } opclass_t;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_UP      = 2'd1,
    RM_DOWN    = 2'd2,
    RM_ZERO    = 2'd3
  } rmode_t;

  localparam int FLAG_W = 6;
  localparam int FL_INV = 0;
  localparam int FL_DZ  = 1;
  localparam int FL_OVF = 2;
  localparam int FL_UNF = 3;
  localparam int FL_INX = 4;
  localparam int FL_IDN = 5;

endpackage

// File: rtl/recip_seed.sv
// Shift-subtract evaluation of round(2^(2*SEED_W+1) / (2*idx+1)) / 2.
module recip_seed #(
  parameter int SEED_W = 9
) (
  input  logic [SEED_W-1:0] idx,
  output logic [SEED_W-1:0] est
);

  localparam int QW = SEED_W + 1;  // quotient bits
  localparam int RW = SEED_W + 2;  // partial remainder bits

  logic [QW-1:0] dvs;
  logic [RW-1:0] part [0:QW-1];
  logic [QW-1:0] quo;
  logic [QW-1:0] rnd;

  assign dvs     = {idx, 1'b1};
  assign part[0] = RW'(1) << SEED_W;

  generate
    for (genvar g = 0; g < QW; g++) begin : g_step
      logic [RW-1:0] sh;
      logic          fit;
      assign sh  = part[g] << 1;
      assign fit = (sh >= {1'b0, dvs});
      assign quo[QW-1-g] = fit;
      if (g < QW - 1) begin : g_next
        assign part[g+1] = fit ? (sh - {1'b0, dvs}) : sh;
      end
    end
  endgenerate

  assign rnd = quo + 1'b1;
  assign est = rnd[QW-1:1];

endmodule

// File: rtl/recip_classify.sv
// Input squash and operand classification, in priority order.
module recip_classify
  import recip_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] opnd,
  input  logic                  ftz,
  output logic [EXP_W+FRAC_W:0] eff,
  output opclass_t              cls,
  output logic                  snan,
  output logic                  squashed
);

  localparam int MW   = EXP_W + FRAC_W;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EOFF = 2 * BIAS - 1;

  logic [EXP_W-1:0]  raw_ex;
  logic [FRAC_W-1:0] raw_fr;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic [MW-1:0]     mag;

  assign raw_ex   = opnd[FRAC_W +: EXP_W];
  assign raw_fr   = opnd[FRAC_W-1:0];
  assign squashed = ftz && (raw_ex == '0) && (raw_fr != '0);
  assign eff      = squashed ? {opnd[MW], {MW{1'b0}}} : opnd;

  assign ex  = eff[FRAC_W +: EXP_W];
  assign fr  = eff[FRAC_W-1:0];
  assign mag = eff[MW-1:0];

  always_comb begin
    snan = 1'b0;
    if (ex == '1 && fr != '0) begin
      cls  = CL_NAN;
      snan = !fr[FRAC_W-1];
    end else if (ex == '1) begin
      cls = CL_INF;
    end else if (mag == '0) begin
      cls = CL_ZERO;
    end else if (mag < (MW'(1) << (FRAC_W - 2))) begin
      cls = CL_TINY;
    end else if (ftz && ex >= EXP_W'(EOFF)) begin
      cls = CL_UFLOW;
    end else begin
      cls = CL_NORM;
    end
  end

endmodule

// File: rtl/fp_recip_estimate.sv
module fp_recip_estimate
  import recip_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int SEED_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] operand,
  input  logic [1:0]            rmode,
  input  logic                  ftz,
  input  logic                  dnan,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] result,
  output logic [FLAG_W-1:0]     flags
);

  localparam int W    = 1 + EXP_W + FRAC_W;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EOFF = 2 * BIAS - 1;
  localparam int EXW  = EXP_W + 2;
  localparam int FB   = SEED_W - 1;

  logic [W-1:0] eff;
  opclass_t     cls;
  logic         snan;
  logic         squashed;

  recip_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .opnd     (operand),
    .ftz      (ftz),
    .eff      (eff),
    .cls      (cls),
    .snan     (snan),
    .squashed (squashed)
  );

  logic                  sgn;
  logic [EXP_W-1:0]      ex;
  logic signed [EXW-1:0] e_n;
  logic [FB-1:0]         idx_frac;
  logic [SEED_W-1:0]     est;
  logic signed [EXW-1:0] rexp;
  logic [FRAC_W-1:0]     base;
  logic [W-1:0]          norm_res;

  assign sgn = eff[W-1];
  assign ex  = eff[FRAC_W +: EXP_W];

  // subnormal normalisation before indexing
  always_comb begin
    if (ex == '0) begin
      if (!eff[FRAC_W-1]) begin
        idx_frac = eff[FRAC_W-3 -: FB];
        e_n      = '1;
      end else begin
        idx_frac = eff[FRAC_W-2 -: FB];
        e_n      = '0;
      end
    end else begin
      idx_frac = eff[FRAC_W-1 -: FB];
      e_n      = signed'({2'b00, ex});
    end
  end

  recip_seed #(.SEED_W(SEED_W)) u_seed (
    .idx (({1'b1, idx_frac})),
    .est (est)
  );

  assign rexp = signed'(EXW'(EOFF)) - e_n;
  assign base = {est[FB-1:0], {(FRAC_W-FB){1'b0}}};

  always_comb begin
    if (rexp == '0) begin
      norm_res = {sgn, {EXP_W{1'b0}}, 1'b1, base[FRAC_W-1:1]};
    end else if (rexp == '1) begin
      norm_res = {sgn, {EXP_W{1'b0}}, 2'b01, base[FRAC_W-1:2]};
    end else begin
      norm_res = {sgn, rexp[EXP_W-1:0], base};
    end
  end

  logic         to_inf;
  logic [W-1:0] res_d;
  logic [FLAG_W-1:0] flg_d;

  always_comb begin
    case (rmode_t'(rmode))
      RM_NEAREST: to_inf = 1'b1;
      RM_UP:      to_inf = !sgn;
      RM_DOWN:    to_inf = sgn;
      default:    to_inf = 1'b0;
    endcase
  end

  always_comb begin
    flg_d         = '0;
    flg_d[FL_IDN] = squashed;
    case (cls)
      CL_NAN: begin
        flg_d[FL_INV] = snan;
        res_d = dnan ? {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}
                     : (eff | (W'(1) << (FRAC_W - 1)));
      end
      CL_INF:  res_d = {sgn, {(W-1){1'b0}}};
      CL_ZERO: begin
        flg_d[FL_DZ] = 1'b1;
        res_d = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end
      CL_TINY: begin
        flg_d[FL_OVF] = 1'b1;
        flg_d[FL_INX] = 1'b1;
        res_d = to_inf ? {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                       : {sgn, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      end
      CL_UFLOW: begin
        flg_d[FL_UNF] = 1'b1;
        res_d = {sgn, {(W-1){1'b0}}};
      end
      default: res_d = norm_res;
    endcase
  end

  logic              vld_q;
  logic [W-1:0]      res_q;
  logic [FLAG_W-1:0] flg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      flg_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        flg_q <= flg_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign flags     = flg_q;

  // R1: one-cycle valid pipeline and hold
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flags)));
  // R8: seed index always yields an estimate in the upper half of its range
  a_r8_seed_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls == CL_NORM) |-> est[SEED_W-1]);
  // R2: any NaN leaving the unit is quiet
  a_r2_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result[W-2 -: EXP_W] == '1 && result[FRAC_W-1:0] != '0)
      |-> result[FRAC_W-1]);
  // R5: overflow and inexact always come together
  a_r5_ovf_inx: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags[FL_OVF] == flags[FL_INX]));
  // R4: divide-by-zero only with an infinite result
  a_r4_dz_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flags[FL_DZ]) |-> (result[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
  // R6: underflow only with a zero result
  a_r6_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flags[FL_UNF]) |-> (result[W-2:0] == '0));

endmodule

// File: tb/tb_fp_recip_estimate.sv
module tb_fp_recip_estimate;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] operand;
  logic [1:0]  rmode;
  logic        ftz;
  logic        dnan;
  logic        out_valid;
  logic [31:0] result;
  logic [5:0]  flags;

  int n_run;
  int n_fail;
  logic done;

  fp_recip_estimate dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .operand   (operand),
    .rmode     (rmode),
    .ftz       (ftz),
    .dnan      (dnan),
    .out_valid (out_valid),
    .result    (result),
    .flags     (flags)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {operand, rmode, ftz, dnan, expected result, expected flags}
  localparam int NV = 32;
  localparam logic [73:0] VEC [NV] = '{
    {32'h3F800000, 2'd0, 1'b0, 1'b0, 32'h3F7F8000, 6'h00},
    {32'h40000000, 2'd0, 1'b0, 1'b0, 32'h3EFF8000, 6'h00},
    {32'h3FC00000, 2'd0, 1'b0, 1'b0, 32'h3F2A8000, 6'h00},
    {32'hC0400000, 2'd0, 1'b0, 1'b0, 32'hBEAA8000, 6'h00},
    {32'h3FFFFFFF, 2'd0, 1'b0, 1'b0, 32'h3F000000, 6'h00},
    {32'h3F400000, 2'd0, 1'b0, 1'b0, 32'h3FAA8000, 6'h00},
    {32'h3F800000, 2'd3, 1'b1, 1'b0, 32'h3F7F8000, 6'h00},
    {32'h7FC00001, 2'd0, 1'b0, 1'b0, 32'h7FC00001, 6'h00},
    {32'h7F800001, 2'd0, 1'b0, 1'b0, 32'h7FC00001, 6'h01},
    {32'hFF800005, 2'd0, 1'b0, 1'b0, 32'hFFC00005, 6'h01},
    {32'h7F800001, 2'd0, 1'b0, 1'b1, 32'h7FC00000, 6'h01},
    {32'hFFC12345, 2'd0, 1'b0, 1'b1, 32'h7FC00000, 6'h00},
    {32'h7F800000, 2'd0, 1'b0, 1'b0, 32'h00000000, 6'h00},
    {32'hFF800000, 2'd0, 1'b0, 1'b0, 32'h80000000, 6'h00},
    {32'h00000000, 2'd0, 1'b0, 1'b0, 32'h7F800000, 6'h02},
    {32'h80000000, 2'd0, 1'b0, 1'b0, 32'hFF800000, 6'h02},
    {32'h00100000, 2'd0, 1'b0, 1'b0, 32'h7F800000, 6'h14},
    {32'h80100000, 2'd1, 1'b0, 1'b0, 32'hFF7FFFFF, 6'h14},
    {32'h80100000, 2'd2, 1'b0, 1'b0, 32'hFF800000, 6'h14},
    {32'h00100000, 2'd3, 1'b0, 1'b0, 32'h7F7FFFFF, 6'h14},
    {32'h00100000, 2'd2, 1'b0, 1'b0, 32'h7F7FFFFF, 6'h14},
    {32'h001FFFFF, 2'd1, 1'b0, 1'b0, 32'h7F800000, 6'h14},
    {32'h7E800000, 2'd0, 1'b1, 1'b0, 32'h00000000, 6'h08},
    {32'hFE800000, 2'd0, 1'b1, 1'b0, 32'h80000000, 6'h08},
    {32'h7F000000, 2'd0, 1'b1, 1'b0, 32'h00000000, 6'h08},
    {32'h7E7FFFFF, 2'd0, 1'b1, 1'b0, 32'h00800000, 6'h00},
    {32'h7E800000, 2'd0, 1'b0, 1'b0, 32'h007FC000, 6'h00},
    {32'h7F000000, 2'd0, 1'b0, 1'b0, 32'h003FE000, 6'h00},
    {32'h00400000, 2'd0, 1'b1, 1'b0, 32'h7F800000, 6'h22},
    {32'h80100000, 2'd0, 1'b1, 1'b0, 32'hFF800000, 6'h22},
    {32'h00400000, 2'd0, 1'b0, 1'b0, 32'h7EFF8000, 6'h00},
    {32'h00200000, 2'd0, 1'b0, 1'b0, 32'h7F7F8000, 6'h00}
  };

  function automatic string tag_of(int i);
    if (i < 7)  return "R8";
    if (i < 10) return "R2";
    if (i < 12) return "R3";
    if (i < 16) return "R4";
    if (i < 22) return "R5";
    if (i < 28) return "R6";
    if (i < 30) return "R7";
    return "R9";
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] op, input logic [1:0] rm,
                       input logic fz, input logic dn);
    @(negedge clk);
    operand  = op;
    rmode    = rm;
    ftz      = fz;
    dnan     = dn;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    done = 1'b0;
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run    = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    operand  = '0;
    rmode    = '0;
    ftz      = 1'b0;
    dnan     = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1", "reset result", result, 32'd0);
    chk("R1", "reset flags", {26'd0, flags}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle out_valid", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][73:42], VEC[i][41:40], VEC[i][39], VEC[i][38]);
      chk("R1", "out_valid after accept", {31'd0, out_valid}, 32'd1);
      chk(tag_of(i), $sformatf("result vec %0d", i), result, VEC[i][37:6]);
      chk(tag_of(i), $sformatf("flags vec %0d", i), {26'd0, flags}, {26'd0, VEC[i][5:0]});
    end

    // R1: hold while in_valid is low, even with a changed operand
    apply(32'h3FC00000, 2'd0, 1'b0, 1'b0);
    operand = 32'h7F800001;
    dnan    = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "out_valid drops", {31'd0, out_valid}, 32'd0);
    chk("R1", "result held", result, 32'h3F2A8000);
    chk("R1", "flags held", {26'd0, flags}, 32'd0);

    // R1: back-to-back operands
    @(negedge clk);
    operand = 32'h40000000; rmode = 2'd0; ftz = 1'b0; dnan = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    chk("R8", "first of pair", result, 32'h3EFF8000);
    operand = 32'h80000000;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4", "second of pair", result, 32'hFF800000);
    chk("R4", "second flags", {26'd0, flags}, 32'h2);
    chk("R1", "valid still high", {31'd0, out_valid}, 32'd1);

    // R1: reset in mid-run clears state
    apply(32'h00100000, 2'd0, 1'b0, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R1", "async reset result", result, 32'd0);
    chk("R1", "async reset flags", {26'd0, flags}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule